// File: doc/BRIEF.md
# Eight-Pin Bidirectional General-Purpose I/O Port

This block is one general-purpose I/O port of a small controller. Every pin has a direction bit, a data bit that serves as the output level or the pull-up request, and a synchronized sample of the pad. Software reaches the port through a simple register bus with three meaningful addresses. Each address is written on the clock edge of a write cycle and is readable in the same cycle through a combinational read path.

On the pad side the block drives an output enable, an output level and a pull-up enable for every pin, and it receives the raw pad level. A global pull-up disable overrides every pull-up. A sleep input clamps the input path to zero, so a floating pad cannot keep the synchronizer toggling while the clock tree idles. The pad level is read through two flip-flops in series.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and data registers are zero, so every pad_oe and pad_pu bit is 0 and a read of address 0 or address 1 returns 0.
- R2: A write to address 0 (direction) loads bus_wdata into the direction register at the clock edge. A 1 makes the pin an output, and pad_oe then equals the register. A read of address 0 returns the register.
- R3: A write to address 1 (data) loads the data register. pad_out always equals that register, and a read of address 1 returns the register contents, not the pad levels.
- R4: pad_pu for a pin is 1 exactly when its direction bit is 0, its data bit is 1 and pull_dis is 0. Clearing the data bit or switching the pin to output turns the pull-up off.
- R5: While pull_dis is 1, every pad_pu bit is 0, whatever the register contents.
- R6: Writing to address 2 (pin) inverts every data bit whose bus_wdata bit is 1 and leaves bits written 0 unchanged. The direction register is not affected.
- R7: A read of address 2 returns pad_in delayed by two clock edges: a change of the pad before edge k shows after edge k+1 and not after edge k.
- R8: While sleep is 1, the sampled pad level is forced to 0. Two edges after sleep rises, a read of address 2 returns 0 for every pin, whatever pad_in does.
- R9: A pin configured as an output still reports its synchronized pad level at address 2.
- R10: Address 3 is unused. A read returns 0, and a write changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 direction, 1 data, 2 pin, 3 unused |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pull_dis | input | 1 | Global pull-up disable |
| sleep | input | 1 | Clamps the input synchronizer to 0 |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
A wrong direction or data bit shows at pad_oe, pad_out and pad_pu right after the edge that stores it, and in the read data at once. Checks therefore sample half a cycle after each write. A fault in the synchronizer shows as a read of address 2 that changes one edge too early or too late, or that fails to settle at zero two edges into sleep. The tests probe those exact edges. Toggle and unused-address faults show as a wrong data or direction value on the next read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     dir_o,
    output logic [W-1:0]     data_o
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] data;
    } regs_t;

    regs_t st_d, st_q;
    sel_e  sel;

    assign sel = sel_e'(bus_addr);

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            case (sel)
                SEL_DIR:  st_d.dir  = bus_wdata;
                SEL_DATA: st_d.data = bus_wdata;
                SEL_PIN:  st_d.data = st_q.data ^ bus_wdata;
                default:  st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o  = st_q.dir;
    assign data_o = st_q.data;

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_DIR) |=> (dir_o == $past(bus_wdata)));

    // R6
    pin_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_PIN) |=>
            (data_o == ($past(data_o) ^ $past(bus_wdata))) && $stable(dir_o));

    // R10
    unused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_NONE) |=> ($stable(dir_o) && $stable(data_o)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t        st_d, st_q;
    logic [W-1:0] gated;

    always_comb begin
        gated = sleep ? '0 : pad_in;
        st_d.s1 = gated;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;

    // R8
    sleep_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(sleep)) |=> (sync_o == '0));

    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !$past(sleep) && $stable(pad_in)) |=> (sync_o == $past(pad_in)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] data_i,
    input  logic         pull_dis,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            pad_oe[i]  = dir_i[i];
            pad_out[i] = data_i[i];
            pad_pu[i]  = !dir_i[i] && data_i[i] && !pull_dis;
        end
    end

    // R5
    pull_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_dis |-> (pad_pu == '0));

    // R4
    pu_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0) && ((pad_pu & ~pad_out) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic             pull_dis,
    input  logic             sleep,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_pu
);
    logic [W-1:0] dir_w, data_w, sync_w;

    gpio_regs #(.W(W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .dir_o(dir_w), .data_o(data_w)
    );

    gpio_sync #(.W(W)) sync_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .pad_in(pad_in), .sync_o(sync_w)
    );

    gpio_pad_ctrl #(.W(W)) pad_i (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_w), .data_i(data_w),
        .pull_dis(pull_dis), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    always_comb begin
        case (sel_e'(bus_addr))
            SEL_DIR:  bus_rdata = dir_w;
            SEL_DATA: bus_rdata = data_w;
            SEL_PIN:  bus_rdata = sync_w;
            default:  bus_rdata = '0;
        endcase
    end

    // R10
    unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_NONE) |-> (bus_rdata == '0));

    // R3
    data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_DATA) |-> (bus_rdata == pad_out));
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [1:0] bus_addr = 0;
    logic       bus_we = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       pull_dis = 0;
    logic       sleep = 0;
    logic [7:0] pad_in = 0;
    logic [7:0] pad_oe, pad_out, pad_pu;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pull_dis(pull_dis),
        .sleep(sleep), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        bus_read(2'd0, v); check("R1 dir read", v, 8'h00);
        bus_read(2'd1, v); check("R1 data read", v, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);
    endtask

    task automatic t_dir_data;
        logic [7:0] v;
        bus_write(2'd0, 8'h3C);
        bus_read(2'd0, v); check("R2 dir read", v, 8'h3C);
        check("R2 pad_oe", pad_oe, 8'h3C);
        pad_in = 8'h00;
        bus_write(2'd1, 8'hA5);
        bus_read(2'd1, v); check("R3 data read not pad", v, 8'hA5);
        check("R3 pad_out", pad_out, 8'hA5);
    endtask

    task automatic t_pullup;
        bus_write(2'd0, 8'h0F);
        bus_write(2'd1, 8'hFF);
        check("R4 pad_pu inputs", pad_pu, 8'hF0);
        bus_write(2'd1, 8'h7F);
        check("R4 pad_pu data cleared", pad_pu, 8'h70);
        bus_write(2'd0, 8'h1F);
        check("R4 pad_pu to output", pad_pu, 8'h60);
        @(negedge clk); pull_dis = 1; #0.5;
        check("R5 pull_dis", pad_pu, 8'h00);
        @(negedge clk); pull_dis = 0; #0.5;
        check("R5 pull_dis released", pad_pu, 8'h60);
    endtask

    task automatic t_toggle;
        logic [7:0] v;
        bus_write(2'd0, 8'h5A);
        bus_write(2'd1, 8'hA5);
        bus_write(2'd2, 8'h0F);
        bus_read(2'd1, v); check("R6 toggle data", v, 8'hAA);
        bus_read(2'd0, v); check("R6 dir untouched", v, 8'h5A);
        bus_write(2'd2, 8'h00);
        bus_read(2'd1, v); check("R6 zero write no change", v, 8'hAA);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        bus_write(2'd0, 8'h00);
        @(negedge clk); pad_in = 8'h00;
        repeat (2) @(negedge clk);
        pad_in = 8'hC3;
        @(negedge clk);
        bus_read(2'd2, v); check("R7 one edge old", v, 8'h00);
        @(negedge clk);
        bus_read(2'd2, v); check("R7 two edges new", v, 8'hC3);
        bus_write(2'd0, 8'hFF);
        pad_in = 8'h96;
        repeat (2) @(negedge clk);
        bus_read(2'd2, v); check("R9 output pin readback", v, 8'h96);
    endtask

    task automatic t_sleep;
        logic [7:0] v;
        pad_in = 8'hFF;
        repeat (2) @(negedge clk);
        bus_read(2'd2, v); check("R8 awake value", v, 8'hFF);
        sleep = 1;
        repeat (2) @(negedge clk);
        bus_read(2'd2, v); check("R8 sleep clamp", v, 8'h00);
        pad_in = 8'h5A;
        repeat (3) @(negedge clk);
        bus_read(2'd2, v); check("R8 pad ignored in sleep", v, 8'h00);
        sleep = 0;
        repeat (2) @(negedge clk);
        bus_read(2'd2, v); check("R8 wake value", v, 8'h5A);
    endtask

    task automatic t_unused;
        logic [7:0] v;
        bus_write(2'd0, 8'h12);
        bus_write(2'd1, 8'h34);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, v); check("R10 unused read", v, 8'h00);
        bus_read(2'd0, v); check("R10 dir kept", v, 8'h12);
        bus_read(2'd1, v); check("R10 data kept", v, 8'h34);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_dir_data;
        t_pullup;
        t_toggle;
        t_sync;
        t_sleep;
        t_unused;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule